// File: doc/BRIEF.md
# Multi-Rail Supply Sequencer

This controller switches the enables of four supply rails on and off in a set order. Each rail is placed in one of eight time slots, or is held off, or is held on. When the global run request rises, the block works upward through the slots. For each slot it waits one programmable delay and then raises the enables of the rails in that slot. It moves to the next slot only after every one of those rails reports that its supply has passed the power-up threshold. When the request falls, it walks the slots from the top down in the same way. It drops the enables and waits for each supply to report that it has fallen below the power-down threshold.

A power-good limit bounds each phase, counted in clock cycles from the first enable that switches. If a phase is still incomplete when the limit runs out, the block latches a fault and pulls every enable low. A cascade flag is high during every inter-slot delay, and a done flag marks a completed power-up. The supply-state flags and the run request come from other clock domains and are synchronized inside the block. The slot configuration and the delay settings must stay stable while a sequence is running.

Top module: `rail_sequencer`

## Requirements
- R1: After reset, cascade, done and fault are low, and the only enables that are high are those of rails configured as forced on.
- R2: Rail c has a 2-bit mode field at cfg_mode[2c+1:2c]. The value 00 places the rail in its slot. The value 10 forces its enable high whenever fault is low, idle included. The values 01 and 11 hold its enable low at all times.
- R3: Rail c has a 3-bit slot field at cfg_slot[3c+2:3c]. Take edge k as the first clock edge that samples run_req high. Cascade rises after edge k+2, and the enables of the lowest occupied slot rise after edge k+3+seq_delay, at the same time as cascade falls.
- R4: Enables rise in ascending slot order, and rails that share a slot rise on the same edge. The delay before the next slot starts only after every rail of the current slot shows supply_up. A rail that never reports up holds all higher slots off.
- R5: Empty slots add no time. The spacing between two occupied slots does not depend on how many empty slots lie between them.
- R6: Done rises once the rails of the highest occupied slot all report up. Done falls two edges after the first edge that samples run_req low, before any enable falls.
- R7: Power-down handles slots in descending order. Each slot gets a delay with cascade high, then its rails' enables fall together. The block waits for supply_down on all of them before it moves on. During power-down, run_req is not looked at until the block is idle again.
- R8: Take edge e as the edge on which the first enable of a phase switches. If the phase is unfinished when the power-good count reaches pg_limit, fault rises after edge e+pg_limit+1 and all enables go low.
- R9: A pg_limit of zero disables the power-good limit, so a stalled sequence waits forever without a fault.
- R10: Fault stays high while run_req stays high. It clears after run_req falls, and a later rise of run_req starts a new power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_req | input | 1 | Global request to power up (high) or power down (low), asynchronous |
| cfg_mode | input | 2*NCH | Per-rail mode field (slotted, off, forced on) |
| cfg_slot | input | 3*NCH | Per-rail slot number 0..7 |
| supply_up | input | NCH | Per-rail flag: supply above its power-up threshold, asynchronous |
| supply_down | input | NCH | Per-rail flag: supply below its power-down threshold, asynchronous |
| seq_delay | input | CW | Inter-slot delay in cycles |
| pg_limit | input | CW | Power-good limit in cycles, zero disables |
| rail_en | output | NCH | Rail enables |
| cascade | output | 1 | High during every inter-slot delay |
| done | output | 1 | Power-up complete |
| fault | output | 1 | Latched power-good timeout |

## Verification
The main function is run through six configurations. These cover a plain one-rail-per-slot ladder and a reversed assignment with a shared slot and empty gaps. They also cover a mix of off, forced and slotted rails, the alternate off code, and a rail whose supply never comes up, once with a limit and once without. A shared slot checks that rails switch together rather than merely in order. The reversed assignment checks that order comes from slot numbers and not from rail numbers. The stalled rail separates a timeout fault from an endless wait, depending on whether the limit is zero. Directed runs pin down the exact edge of the first enable. They also compare the slot spacing with and without empty slots in between, and they check that a fault stays latched and is then released.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

    localparam int SLOTS  = 8;
    localparam int SLOT_W = 3;

    typedef enum logic [1:0] {
        MODE_SLOT    = 2'b00,
        MODE_OFF     = 2'b01,
        MODE_FORCE   = 2'b10,
        MODE_OFF_ALT = 2'b11
    } ch_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UP_DLY,
        ST_UP_WAIT,
        ST_DONE,
        ST_DN_DLY,
        ST_DN_WAIT,
        ST_FAULT
    } seq_state_e;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] idx;
    } slot_pick_t;

    // lowest occupied slot at or above 'from' (from may equal SLOTS: none)
    function automatic slot_pick_t pick_up(input logic [SLOTS-1:0] occ,
                                           input logic [SLOT_W:0]  from);
        slot_pick_t r;
        r = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (occ[i] && (i >= int'(from))) begin
                r.hit = 1'b1;
                r.idx = SLOT_W'(i);
            end
        end
        return r;
    endfunction

    // highest occupied slot strictly below 'below'
    function automatic slot_pick_t pick_down(input logic [SLOTS-1:0] occ,
                                             input logic [SLOT_W:0]  below);
        slot_pick_t r;
        r = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (occ[i] && (i < int'(below))) begin
                r.hit = 1'b1;
                r.idx = SLOT_W'(i);
            end
        end
        return r;
    endfunction

    function automatic logic in_phase(input seq_state_e s);
        return (s == ST_UP_DLY) || (s == ST_UP_WAIT) ||
               (s == ST_DN_DLY) || (s == ST_DN_WAIT);
    endfunction

endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rseq_counter.sv
module rseq_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && (cnt != TOP))
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rseq_slot_map.sv
module rseq_slot_map
    import rseq_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic [2*NCH-1:0]            cfg_mode,
    input  logic [SLOT_W*NCH-1:0]       cfg_slot,
    output logic [SLOTS-1:0][NCH-1:0]   member,
    output logic [SLOTS-1:0]            occ,
    output logic [NCH-1:0]              force_mask
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ch_mode_e m;
        assign m             = ch_mode_e'(cfg_mode[2*c +: 2]);
        assign force_mask[c] = (m == MODE_FORCE);
        for (genvar s = 0; s < SLOTS; s++) begin : g_sl
            assign member[s][c] = (m == MODE_SLOT) &&
                                  (cfg_slot[SLOT_W*c +: SLOT_W] == SLOT_W'(s));
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_occ
        assign occ[s] = |member[s];
    end
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
    import rseq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run_req,
    input  logic [2*NCH-1:0]      cfg_mode,
    input  logic [SLOT_W*NCH-1:0] cfg_slot,
    input  logic [NCH-1:0]        supply_up,
    input  logic [NCH-1:0]        supply_down,
    input  logic [CW-1:0]         seq_delay,
    input  logic [CW-1:0]         pg_limit,
    output logic [NCH-1:0]        rail_en,
    output logic                  cascade,
    output logic                  done,
    output logic                  fault
);
    localparam int SW = 1 + 2 * NCH;
    localparam logic [SLOT_W:0] ALL_BELOW = (SLOT_W + 1)'(SLOTS);

    // synchronized inputs
    logic [SW-1:0]  sync_q;
    logic           on_s;
    logic [NCH-1:0] up_s, dn_s;

    rseq_sync #(.W(SW)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({run_req, supply_up, supply_down}),
        .q   (sync_q)
    );
    assign {on_s, up_s, dn_s} = sync_q;

    // configuration decode
    logic [SLOTS-1:0][NCH-1:0] member;
    logic [SLOTS-1:0]          occ;
    logic [NCH-1:0]            force_mask;

    rseq_slot_map #(.NCH(NCH)) u_map (
        .cfg_mode   (cfg_mode),
        .cfg_slot   (cfg_slot),
        .member     (member),
        .occ        (occ),
        .force_mask (force_mask)
    );

    // state
    seq_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [NCH-1:0]    en_q, en_d;
    logic              pg_run_q, pg_run_d;

    // counters
    logic          dly_clr, dly_inc, pg_clr;
    logic [CW-1:0] dly_cnt, pg_cnt;

    assign dly_inc = (state_q == ST_UP_DLY) || (state_q == ST_DN_DLY);

    rseq_counter #(.CW(CW)) u_dly (
        .clk (clk),
        .rst (rst),
        .clr (dly_clr),
        .inc (dly_inc),
        .cnt (dly_cnt)
    );

    rseq_counter #(.CW(CW)) u_pg (
        .clk (clk),
        .rst (rst),
        .clr (pg_clr),
        .inc (pg_run_q),
        .cnt (pg_cnt)
    );

    // next state
    logic            timed_out, dly_done, go_dn;
    logic [NCH-1:0]  cur_mem;
    logic [SLOT_W:0] dn_below, slot_next;
    slot_pick_t      pick;

    assign cur_mem   = member[slot_q];
    assign dly_done  = (dly_cnt == seq_delay);
    assign slot_next = {1'b0, slot_q} + 1'b1;
    assign timed_out = pg_run_q && (pg_limit != '0) && (pg_cnt == pg_limit) &&
                       in_phase(state_q);

    always_comb begin
        state_d  = state_q;
        slot_d   = slot_q;
        en_d     = en_q;
        pg_run_d = pg_run_q;
        dly_clr  = 1'b0;
        pg_clr   = 1'b0;
        go_dn    = 1'b0;
        dn_below = '0;
        pick     = '0;

        if (timed_out) begin
            state_d  = ST_FAULT;
            en_d     = '0;
            pg_run_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    en_d     = '0;
                    pg_run_d = 1'b0;
                    if (on_s) begin
                        pick = pick_up(occ, '0);
                        if (pick.hit) begin
                            state_d = ST_UP_DLY;
                            slot_d  = pick.idx;
                            dly_clr = 1'b1;
                        end else begin
                            state_d = ST_DONE;
                        end
                    end
                end
                ST_UP_DLY: begin
                    if (!on_s) begin
                        go_dn    = 1'b1;
                        dn_below = {1'b0, slot_q};
                    end else if (dly_done) begin
                        en_d    = en_q | cur_mem;
                        state_d = ST_UP_WAIT;
                        if (!pg_run_q) begin
                            pg_run_d = 1'b1;
                            pg_clr   = 1'b1;
                        end
                    end
                end
                ST_UP_WAIT: begin
                    if (!on_s) begin
                        go_dn    = 1'b1;
                        dn_below = slot_next;
                    end else if ((cur_mem & ~up_s) == '0) begin
                        pick = pick_up(occ, slot_next);
                        if (pick.hit) begin
                            state_d = ST_UP_DLY;
                            slot_d  = pick.idx;
                            dly_clr = 1'b1;
                        end else begin
                            state_d  = ST_DONE;
                            pg_run_d = 1'b0;
                        end
                    end
                end
                ST_DONE: begin
                    if (!on_s) begin
                        go_dn    = 1'b1;
                        dn_below = ALL_BELOW;
                    end
                end
                ST_DN_DLY: begin
                    if (dly_done) begin
                        en_d    = en_q & ~cur_mem;
                        state_d = ST_DN_WAIT;
                        if (!pg_run_q) begin
                            pg_run_d = 1'b1;
                            pg_clr   = 1'b1;
                        end
                    end
                end
                ST_DN_WAIT: begin
                    if ((cur_mem & ~dn_s) == '0) begin
                        pick = pick_down(occ, {1'b0, slot_q});
                        if (pick.hit) begin
                            state_d = ST_DN_DLY;
                            slot_d  = pick.idx;
                            dly_clr = 1'b1;
                        end else begin
                            state_d  = ST_IDLE;
                            en_d     = '0;
                            pg_run_d = 1'b0;
                        end
                    end
                end
                ST_FAULT: begin
                    en_d     = '0;
                    pg_run_d = 1'b0;
                    if (!on_s)
                        state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase

            if (go_dn) begin
                pick     = pick_down(occ, dn_below);
                pg_run_d = 1'b0;
                if (pick.hit) begin
                    state_d = ST_DN_DLY;
                    slot_d  = pick.idx;
                    dly_clr = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                    en_d    = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            slot_q   <= '0;
            en_q     <= '0;
            pg_run_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            slot_q   <= slot_d;
            en_q     <= en_d;
            pg_run_q <= pg_run_d;
        end
    end

    // outputs
    assign fault   = (state_q == ST_FAULT);
    assign done    = (state_q == ST_DONE);
    assign cascade = dly_inc;
    assign rail_en = fault ? '0 : (en_q | force_mask);

endmodule

// File: rtl/rseq_chk.sv
module rseq_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           on_sync,
    input logic [2*NCH-1:0] cfg_mode,
    input logic [NCH-1:0] rail_en,
    input logic           cascade,
    input logic           done,
    input logic           fault
);
    logic [NCH-1:0] off_m, force_m, slot_m;

    for (genvar c = 0; c < NCH; c++) begin : g_m
        assign off_m[c]   = cfg_mode[2*c];
        assign force_m[c] = (cfg_mode[2*c +: 2] == 2'b10);
        assign slot_m[c]  = (cfg_mode[2*c +: 2] == 2'b00);
    end

    // R8
    fault_blanks_en_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> (rail_en == '0));

    // R2
    off_rail_low_chk: assert property (@(posedge clk) disable iff (rst)
        (rail_en & off_m) == '0);

    // R2
    forced_rail_high_chk: assert property (@(posedge clk) disable iff (rst)
        !fault |-> ((rail_en & force_m) == force_m));

    // R6
    done_all_on_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ((rail_en & slot_m) == slot_m));

    // R10
    fault_held_chk: assert property (@(posedge clk) disable iff (rst)
        (fault && on_sync) |=> fault);

    // R3
    cascade_excl_chk: assert property (@(posedge clk) disable iff (rst)
        cascade |-> (!done && !fault));
endmodule

bind rail_sequencer rseq_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .on_sync  (on_s),
    .cfg_mode (cfg_mode),
    .rail_en  (rail_en),
    .cascade  (cascade),
    .done     (done),
    .fault    (fault)
);

// File: tb/rail_sequencer_test.sv
module rail_sequencer_test;
    localparam int NCH = 4;
    localparam int CW  = 16;

    typedef struct packed {
        logic [7:0]  mode;
        logic [11:0] slot;
        logic [15:0] dly;
        logic [15:0] pgl;
        logic [3:0]  stuck;
        logic        exp_done;
        logic        exp_fault;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{8'h00, 12'h688, 16'd4, 16'd0,   4'b0000, 1'b1, 1'b0},
        '{8'h00, 12'h36F, 16'd2, 16'd300, 4'b0000, 1'b1, 1'b0},
        '{8'h09, 12'hCC0, 16'd3, 16'd0,   4'b0000, 1'b1, 1'b0},
        '{8'hC0, 12'h112, 16'd1, 16'd0,   4'b0000, 1'b1, 1'b0},
        '{8'h00, 12'h688, 16'd4, 16'd60,  4'b0100, 1'b0, 1'b1},
        '{8'h00, 12'h688, 16'd4, 16'd0,   4'b0100, 1'b0, 1'b0}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            run_req = 1'b0;
    logic [7:0]      cfg_mode = '0;
    logic [11:0]     cfg_slot = '0;
    logic [NCH-1:0]  supply_up = '0;
    logic [NCH-1:0]  supply_down = '1;
    logic [CW-1:0]   seq_delay = '0;
    logic [CW-1:0]   pg_limit = '0;
    logic [NCH-1:0]  rail_en;
    logic            cascade, done, fault;

    rail_sequencer #(.NCH(NCH), .CW(CW)) uut (
        .clk         (clk),
        .rst         (rst),
        .run_req     (run_req),
        .cfg_mode    (cfg_mode),
        .cfg_slot    (cfg_slot),
        .supply_up   (supply_up),
        .supply_down (supply_down),
        .seq_delay   (seq_delay),
        .pg_limit    (pg_limit),
        .rail_en     (rail_en),
        .cascade     (cascade),
        .done        (done),
        .fault       (fault)
    );

    int checks = 0;
    int errs   = 0;
    int cyc    = 0;

    // supply model and event recorder
    logic [NCH-1:0] stuck = '0;
    logic           rec_clear = 1'b0;
    int             rise_t [NCH];
    int             fall_t [NCH];
    int             hi_cnt [NCH];
    int             lo_cnt [NCH];
    int             fault_t = -1;
    logic [NCH-1:0] ever_hi = '0;
    logic [NCH-1:0] prev_en = '0;

    initial forever #4 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            rise_t[c] = -1; fall_t[c] = -1; hi_cnt[c] = 0; lo_cnt[c] = 10;
        end
        forever begin
            @(negedge clk);
            if (rec_clear) begin
                for (int c = 0; c < NCH; c++) begin
                    rise_t[c] = -1; fall_t[c] = -1;
                end
                ever_hi = '0;
                fault_t = -1;
            end
            for (int c = 0; c < NCH; c++) begin
                if (rail_en[c]) begin
                    if (hi_cnt[c] < 1000) hi_cnt[c]++;
                    lo_cnt[c] = 0;
                end else begin
                    if (lo_cnt[c] < 1000) lo_cnt[c]++;
                    hi_cnt[c] = 0;
                end
                if (rail_en[c] && !prev_en[c] && rise_t[c] < 0) rise_t[c] = cyc;
                if (!rail_en[c] && prev_en[c] && fall_t[c] < 0) fall_t[c] = cyc;
                supply_up[c]   = (hi_cnt[c] >= 3) && !stuck[c];
                supply_down[c] = (lo_cnt[c] >= 3);
            end
            ever_hi = ever_hi | rail_en;
            if (fault && fault_t < 0) fault_t = cyc;
            prev_en = rail_en;
        end
    end

    task automatic summary_and_end();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        summary_and_end();
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sgn(input int x);
        return (x > 0) ? 1 : ((x < 0) ? -1 : 0);
    endfunction

    function automatic logic [NCH-1:0] force_of(input logic [7:0] m);
        logic [NCH-1:0] r;
        for (int c = 0; c < NCH; c++) r[c] = (m[2*c +: 2] == 2'b10);
        return r;
    endfunction

    task automatic clear_rec();
        rec_clear = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rec_clear = 1'b0;
    endtask

    task automatic apply_cfg(input logic [7:0] m, input logic [11:0] s,
                             input logic [15:0] d, input logic [15:0] p,
                             input logic [3:0] st);
        cfg_mode  = m;
        cfg_slot  = s;
        seq_delay = d;
        pg_limit  = p;
        stuck     = st;
        @(negedge clk);
    endtask

    task automatic wait_up(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (done || fault) break;
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (!done && !fault && !cascade && rail_en == force_of(cfg_mode)) break;
        end
        repeat (20) @(negedge clk);
    endtask

    int d_a, d_b, first;

    initial begin
        // R1: reset state
        cfg_mode = 8'h09;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 rail_en forced only", int'(rail_en), 4'b0010);
        check_eq("R1 cascade", int'(cascade), 0);
        check_eq("R1 done", int'(done), 0);
        check_eq("R1 fault", int'(fault), 0);

        // vector table
        for (int i = 0; i < 6; i++) begin
            vec_t v;
            v = VEC[i];
            apply_cfg(v.mode, v.slot, v.dly, v.pgl, v.stuck);
            clear_rec();
            run_req = 1'b1;
            wait_up(500);
            check_eq($sformatf("R6/R9 done v%0d", i), int'(done), int'(v.exp_done));
            check_eq($sformatf("R8/R9 fault v%0d", i), int'(fault), int'(v.exp_fault));
            for (int a = 0; a < NCH; a++) begin
                if (v.mode[2*a] == 1'b1)
                    check_eq($sformatf("R2 off rail %0d v%0d", a, i), int'(ever_hi[a]), 0);
                if (v.mode[2*a +: 2] == 2'b10 && !v.exp_fault)
                    check_eq($sformatf("R2 forced rail %0d v%0d", a, i), int'(rail_en[a]), 1);
                for (int b = a + 1; b < NCH; b++) begin
                    if (v.mode[2*a +: 2] == 2'b00 && v.mode[2*b +: 2] == 2'b00 &&
                        rise_t[a] >= 0 && rise_t[b] >= 0)
                        check_eq($sformatf("R4 order %0d/%0d v%0d", a, b, i),
                                 sgn(rise_t[a] - rise_t[b]),
                                 sgn(int'(v.slot[3*a +: 3]) - int'(v.slot[3*b +: 3])));
                end
            end
            if (v.stuck != 0) begin
                // R4: rail 3 sits above the stalled slot and must stay off
                check_eq($sformatf("R4 held off v%0d", i), rise_t[3], -1);
            end
            if (v.exp_fault) begin
                first = rise_t[0];
                check_eq("R8 timeout edge", fault_t - first, int'(v.pgl) + 1);
                check_eq("R8 enables low", int'(rail_en), 0);
            end
            clear_rec();
            run_req = 1'b0;
            wait_idle();
            if (v.exp_fault)
                check_eq("R10 fault released", int'(fault), 0);
            if (v.exp_done) begin
                for (int a = 0; a < NCH; a++)
                    for (int b = a + 1; b < NCH; b++)
                        if (v.mode[2*a +: 2] == 2'b00 && v.mode[2*b +: 2] == 2'b00)
                            check_eq($sformatf("R7 order %0d/%0d v%0d", a, b, i),
                                     sgn(fall_t[a] - fall_t[b]),
                                     sgn(int'(v.slot[3*b +: 3]) - int'(v.slot[3*a +: 3])));
            end
            check_eq($sformatf("R7 idle v%0d", i), int'(rail_en), int'(force_of(v.mode)));
        end

        // R3: exact edge of first enable and cascade window
        apply_cfg(8'h54, 12'h000, 16'd5, 16'd0, 4'b0000);
        run_req = 1'b1;
        @(posedge clk);              // edge k samples run_req
        @(posedge clk); @(negedge clk);
        check_eq("R3 cascade after k+1", int'(cascade), 0);
        @(posedge clk); @(negedge clk);
        check_eq("R3 cascade after k+2", int'(cascade), 1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check_eq("R3 rail0 after k+2+d", int'(rail_en[0]), 0);
        check_eq("R3 cascade after k+2+d", int'(cascade), 1);
        @(posedge clk); @(negedge clk);
        check_eq("R3 rail0 after k+3+d", int'(rail_en[0]), 1);
        check_eq("R3 cascade after k+3+d", int'(cascade), 0);
        run_req = 1'b0;
        wait_idle();

        // R5: spacing with adjacent slots vs. with empty slots between
        apply_cfg(8'h50, 12'h008, 16'd4, 16'd0, 4'b0000);
        clear_rec();
        run_req = 1'b1;
        wait_up(300);
        d_a = rise_t[1] - rise_t[0];
        // R6 / R7: done drops before any enable falls
        run_req = 1'b0;
        @(posedge clk);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_eq("R6 done cleared", int'(done), 0);
        check_eq("R7 delay before fall", int'(cascade), 1);
        check_eq("R7 rails still on", int'(rail_en[1:0]), 3);
        wait_idle();
        apply_cfg(8'h50, 12'h030, 16'd4, 16'd0, 4'b0000);
        clear_rec();
        run_req = 1'b1;
        wait_up(300);
        d_b = rise_t[1] - rise_t[0];
        check_eq("R5 empty slots skipped", d_b, d_a);
        run_req = 1'b0;
        wait_idle();

        // R10: fault latched while request high, then a fresh start
        apply_cfg(8'h00, 12'h688, 16'd2, 16'd40, 4'b0100);
        run_req = 1'b1;
        wait_up(300);
        repeat (50) @(negedge clk);
        check_eq("R10 fault held", int'(fault), 1);
        run_req = 1'b0;
        repeat (6) @(negedge clk);
        check_eq("R10 fault cleared", int'(fault), 0);
        stuck = 4'b0000;
        run_req = 1'b1;
        wait_up(300);
        check_eq("R10 restart reaches done", int'(done), 1);
        run_req = 1'b0;
        wait_idle();

        summary_and_end();
    end
endmodule